// File: doc/BRIEF.md
# SPI Slave Serial Front End with Bus Pause

This block is the serial edge of an SPI slave peripheral. It runs from a system clock that is much faster than the serial clock. The serial clock, chip select, data-in and pause-request pins are brought into the system-clock domain, and edges of the serial clock are found there. Each active edge then moves one bit. Incoming bits are shifted in most significant bit first. Each completed word is handed to the core together with a one-cycle valid strobe. An outgoing word, supplied in parallel by the core, is shifted out most significant bit first on the opposite edge. The block works with the serial clock idling low (mode 0) or idling high (mode 3), and it needs no configuration to tell the two apart.

A pause input, active low, lets the bus master borrow the serial lines while a transaction is half done. The pause starts and ends only while the serial clock is low. When the pause input changes while the clock is high, the block waits for the next falling clock edge. While paused, the data-out enable is dropped, clock and data edges have no effect, and the partial word and the outgoing shift state are kept. Raising chip select at any time, including during a pause, throws the transaction away. The core also gets a start pulse each time chip select falls. Command decoding and storage belong to the core.

Top module: `spi_hold_slave`

## Requirements
- R1: After reset, with chip select high, `misoOe`, `rxValid` and `startPulse` are all 0.
- R2: Data-in is sampled on rising serial clock edges, most significant bit first. After the eighth rising edge of a word, `rxWord` holds the eight sampled bits (the first one in bit 7) and `rxValid` is high for exactly one system clock.
- R3: `txWord` is loaded when chip select falls, and its bit 7 appears on `misoOut` before the first rising edge. Each falling edge inside a word moves on to the next lower bit. The falling edge that follows the eighth rising edge loads a fresh `txWord`.
- R4: In mode 3, the falling edge that comes before the first rising edge of a transaction does not shift the outgoing word, so the first bit seen at the first rising edge is still `txWord` bit 7.
- R5: `startPulse` is high for exactly one system clock for each falling edge of chip select.
- R6: `misoOe` is 0 whenever chip select is high.
- R7: If the pause input falls while the serial clock is low, the pause starts at once. While paused, `misoOe` is 0 and serial clock edges neither shift data nor raise `rxValid`. After release, the word goes on from the bit where it stopped.
- R8: If the pause input falls while the serial clock is high, `misoOe` stays 1 until the next falling clock edge. That falling edge still shifts the outgoing word, and the pause begins after it.
- R9: If the pause input rises while the serial clock is high, the pause lasts until the next falling clock edge, and that falling edge does not shift the outgoing word.
- R10: Raising chip select during a pause ends the pause and clears the transaction. The next transaction starts at bit 7 in both directions, and no word from the cleared transaction is ever reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples all pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkPin | input | 1 | Serial clock from the master |
| csNPin | input | 1 | Chip select, active low |
| mosiPin | input | 1 | Serial data in |
| holdNPin | input | 1 | Pause request, active low |
| txWord | input | 8 | Word from the core to be shifted out |
| rxWord | output | 8 | Last complete received word |
| rxValid | output | 1 | One-cycle strobe when rxWord is updated |
| startPulse | output | 1 | One-cycle pulse when chip select falls |
| misoOut | output | 1 | Serial data-out value |
| misoOe | output | 1 | Drive enable for the data-out pad |

## Verification
Full words are sent in mode 0 and in mode 3 with mixed bit patterns such as 0xA5, 0x81 and 0x6B. A two-word transfer shows whether the word boundary reloads the outgoing data. The mode 3 runs show whether the extra leading falling edge wrongly shifts the outgoing word. Pauses are entered with the clock low and with it high, and released with it low and with it high, partway through a word and with clock toggles while paused. The recovered word and the data-out bits that follow each case show whether an edge was wrongly counted or dropped. A transfer where chip select is raised during a pause, followed by a fresh word, shows whether stale bits leak into the next transaction.

// File: rtl/spih_pkg.sv
package spih_pkg;
  typedef struct packed {
    logic start;   // chip select just fell
    logic sample;  // qualified rising serial clock edge
    logic drive;   // qualified falling serial clock edge
    logic abort;   // chip select is high: clear the transaction
  } spihStrobe_t;
endpackage

// File: rtl/spih_sync.sv
module spih_sync #(
  parameter int STAGES = 2,
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= RST_VAL;
    else       stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[s] <= RST_VAL;
      else       stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/spih_ctrl.sv
module spih_ctrl
  import spih_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkLvl,
  input  logic        csLvl,
  input  logic        holdLvl,
  output spihStrobe_t strobe,
  output logic        holdActive
);
  logic sclkD, csD, heldQ, heldNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkD <= 1'b0;
      csD   <= 1'b1;
      heldQ <= 1'b0;
    end else begin
      sclkD <= sclkLvl;
      csD   <= csLvl;
      heldQ <= heldNext;
    end
  end

  // pause may change state only while the serial clock is low
  always_comb begin
    heldNext = heldQ;
    if (csLvl)                               heldNext = 1'b0;
    else if (!heldQ && !holdLvl && !sclkLvl) heldNext = 1'b1;
    else if (heldQ && holdLvl && !sclkLvl)   heldNext = 1'b0;
  end

  always_comb begin
    strobe.start  = !csLvl && csD;
    strobe.sample = !csLvl && !heldQ && sclkLvl && !sclkD;
    strobe.drive  = !csLvl && !heldQ && !sclkLvl && sclkD;
    strobe.abort  = csLvl;
  end

  assign holdActive = heldQ;

  assert_pause_cleared_R10: assert property (@(posedge clk) disable iff (!rstN)
    csLvl |=> !heldQ);
  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> !strobe.start);
  assert_enter_clk_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(heldQ) |-> !$past(sclkLvl));
  assert_exit_clk_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(heldQ) && !$past(csLvl)) |-> !$past(sclkLvl));
endmodule

// File: rtl/spih_datapath.sv
module spih_datapath
  import spih_pkg::*;
#(
  parameter int W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  spihStrobe_t strobe,
  input  logic        diLvl,
  input  logic [W-1:0] txWord,
  output logic [W-1:0] rxWord,
  output logic        rxValid,
  output logic        txBit
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] bitCnt;
  logic [W-2:0]  rxShift;
  logic [W-1:0]  txShift;
  logic          wordDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      txShift  <= '0;
      wordDone <= 1'b0;
      rxWord   <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strobe.abort) begin
        bitCnt   <= '0;
        wordDone <= 1'b0;
      end else if (strobe.start) begin
        bitCnt   <= '0;
        wordDone <= 1'b0;
        txShift  <= txWord;
      end else begin
        if (strobe.sample) begin
          rxShift <= {rxShift[W-3:0], diLvl};
          if (bitCnt == LAST) begin
            rxWord   <= {rxShift, diLvl};
            rxValid  <= 1'b1;
            bitCnt   <= '0;
            wordDone <= 1'b1;
          end else begin
            bitCnt <= bitCnt + CW'(1);
          end
        end
        if (strobe.drive) begin
          if (bitCnt != '0) begin
            txShift <= {txShift[W-2:0], 1'b0};
          end else if (wordDone) begin
            txShift  <= txWord;
            wordDone <= 1'b0;
          end
        end
      end
    end
  end

  assign txBit = txShift[W-1];

  assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  assert_valid_at_boundary_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (bitCnt == '0));
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
  import spih_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkPin,
  input  logic              csNPin,
  input  logic              mosiPin,
  input  logic              holdNPin,
  input  logic [WORD_W-1:0] txWord,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  output logic              startPulse,
  output logic              misoOut,
  output logic              misoOe
);
  localparam logic [3:0] PIN_RST = 4'b0101; // {sclk, csN, mosi, holdN}

  logic [3:0]  pinLvl;
  spihStrobe_t strobe;
  logic        holdActive;

  spih_sync #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(PIN_RST)) sync_i (
    .clk(clk), .rstN(rstN),
    .din({sclkPin, csNPin, mosiPin, holdNPin}),
    .dout(pinLvl)
  );

  spih_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .sclkLvl(pinLvl[3]), .csLvl(pinLvl[2]), .holdLvl(pinLvl[0]),
    .strobe(strobe), .holdActive(holdActive)
  );

  spih_datapath #(.W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .diLvl(pinLvl[1]),
    .txWord(txWord), .rxWord(rxWord), .rxValid(rxValid), .txBit(misoOut)
  );

  assign startPulse = strobe.start;
  assign misoOe     = !pinLvl[2] && !holdActive;

  assert_oe_off_deselected_R6: assert property (@(posedge clk) disable iff (!rstN)
    pinLvl[2] |-> !misoOe);
endmodule

// File: tb/spi_hold_slave_tb_top.sv
module spi_hold_slave_tb_top;
  localparam int HP = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclkPin = 1'b0, csNPin = 1'b1, mosiPin = 1'b0, holdNPin = 1'b1;
  logic [7:0] txWord = 8'h00;
  logic [7:0] rxWord;
  logic rxValid, startPulse, misoOut, misoOe;

  int nRun = 0, nFail = 0;
  int rxCnt = 0, startCnt = 0;
  logic [7:0] lastRx = 8'h00;

  always #10 clk = ~clk;

  spi_hold_slave dut_i (
    .clk(clk), .rstN(rstN), .sclkPin(sclkPin), .csNPin(csNPin),
    .mosiPin(mosiPin), .holdNPin(holdNPin), .txWord(txWord),
    .rxWord(rxWord), .rxValid(rxValid), .startPulse(startPulse),
    .misoOut(misoOut), .misoOe(misoOe)
  );

  always @(negedge clk) begin
    if (rxValid) begin rxCnt++; lastRx = rxWord; end
    if (startPulse) startCnt++;
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bit: drop clock, present data, sample data-out, raise clock
  task automatic bitXfer(input logic d, output logic seen);
    sclkPin = 1'b0; mosiPin = d; waitCyc(HP);
    seen = misoOut;
    sclkPin = 1'b1; waitCyc(HP);
  endtask

  task automatic sendWord(input logic [7:0] b, output logic [7:0] seen);
    for (int i = 7; i >= 0; i--) bitXfer(b[i], seen[i]);
  endtask

  task automatic tReset;
    waitCyc(2);
    check("R1 oe", misoOe, 0);
    check("R1 valid", rxCnt, 0);
    check("R1 start", startCnt, 0);
  endtask

  task automatic tMode0;
    logic [7:0] seen;
    int r0, s0;
    r0 = rxCnt; s0 = startCnt;
    sclkPin = 0; txWord = 8'h3C; waitCyc(HP);
    csNPin = 0; waitCyc(HP);
    check("R5 start pulse", startCnt - s0, 1);
    check("R6 oe selected", misoOe, 1);
    txWord = 8'hC3;
    sendWord(8'hA5, seen);
    waitCyc(2);
    check("R2 rx word", lastRx, 8'hA5);
    check("R2 one strobe", rxCnt - r0, 1);
    check("R3 tx word", seen, 8'h3C);
    sendWord(8'h5A, seen);
    waitCyc(2);
    check("R3 next tx word", seen, 8'hC3);
    check("R2 second rx", lastRx, 8'h5A);
    sclkPin = 0; waitCyc(HP);
    csNPin = 1; waitCyc(HP);
    check("R6 oe deselected", misoOe, 0);
  endtask

  task automatic tMode3;
    logic [7:0] seen;
    sclkPin = 1; txWord = 8'hE7; waitCyc(HP);
    csNPin = 0; waitCyc(HP);
    sendWord(8'h81, seen);
    waitCyc(2);
    check("R4 mode3 tx", seen, 8'hE7);
    check("R2 mode3 rx", lastRx, 8'h81);
    csNPin = 1; waitCyc(HP);
    sclkPin = 0; waitCyc(HP);
  endtask

  task automatic tHoldLow;
    logic [7:0] seen;
    logic s;
    int r0;
    txWord = 8'h96; waitCyc(HP);
    csNPin = 0; waitCyc(HP);
    r0 = rxCnt;
    for (int i = 7; i >= 4; i--) bitXfer(logic'(i[0]), seen[i]);
    sclkPin = 0; waitCyc(HP);
    holdNPin = 0; waitCyc(HP);
    check("R7 oe off in pause", misoOe, 0);
    for (int k = 0; k < 6; k++) begin
      mosiPin = 1; sclkPin = 1; waitCyc(HP); sclkPin = 0; waitCyc(HP);
    end
    check("R7 no strobe in pause", rxCnt - r0, 0);
    holdNPin = 1; waitCyc(HP);
    check("R7 oe back", misoOe, 1);
    for (int i = 3; i >= 0; i--) bitXfer(logic'(i[0]), seen[i]);
    waitCyc(2);
    check("R7 tx kept", seen, 8'h96);
    check("R7 rx kept", lastRx, 8'hAA);
    check("R7 one strobe", rxCnt - r0, 1);
    sclkPin = 0; waitCyc(HP);
    csNPin = 1; waitCyc(HP);
  endtask

  task automatic tHoldHigh;
    logic [7:0] seen;
    txWord = 8'hB4; waitCyc(HP);
    csNPin = 0; waitCyc(HP);
    for (int i = 7; i >= 4; i--) bitXfer(1'b0, seen[i]);
    holdNPin = 0; waitCyc(HP);
    check("R8 oe until fall", misoOe, 1);
    sclkPin = 0; waitCyc(HP);
    check("R8 oe off after fall", misoOe, 0);
    mosiPin = 1; sclkPin = 1; waitCyc(HP);
    holdNPin = 1; waitCyc(HP);
    check("R9 still paused clk high", misoOe, 0);
    sclkPin = 0; waitCyc(HP);
    check("R9 oe after fall", misoOe, 1);
    for (int i = 3; i >= 0; i--) bitXfer(1'b1, seen[i]);
    waitCyc(2);
    check("R8 R9 tx order", seen, 8'hB4);
    check("R8 R9 rx word", lastRx, 8'h0F);
    sclkPin = 0; waitCyc(HP);
    csNPin = 1; waitCyc(HP);
  endtask

  task automatic tCsAbort;
    logic [7:0] seen;
    logic s;
    int r0;
    txWord = 8'h55; waitCyc(HP);
    csNPin = 0; waitCyc(HP);
    r0 = rxCnt;
    for (int i = 0; i < 3; i++) bitXfer(1'b1, s);
    sclkPin = 0; waitCyc(HP);
    holdNPin = 0; waitCyc(HP);
    csNPin = 1; waitCyc(HP);
    check("R10 oe off", misoOe, 0);
    holdNPin = 1; txWord = 8'h99; waitCyc(HP);
    csNPin = 0; waitCyc(HP);
    check("R10 oe fresh", misoOe, 1);
    sendWord(8'h6B, seen);
    waitCyc(2);
    check("R10 rx fresh", lastRx, 8'h6B);
    check("R10 tx fresh", seen, 8'h99);
    check("R10 one strobe", rxCnt - r0, 1);
    sclkPin = 0; waitCyc(HP);
    csNPin = 1; waitCyc(HP);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    tReset();
    tMode0();
    tMode3();
    tHoldLow();
    tHoldHigh();
    tCsAbort();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule